// File: doc/BRIEF.md
# Multi-Channel DMA Transfer Controller

This block copies words from one memory location to another without processor work. It has three channels. Each channel holds its own source address, destination address, word count, trigger choice and transfer mode. Software sets these up through a small word-addressed register port. A transfer starts on a rising edge of the trigger input that the channel selects. The controller then asks for the system bus with a request/grant handshake. Once granted, it moves each word as one read cycle followed by one write cycle.

A channel can run in three kinds of transfer, each in a one-shot or a repeating form. Single mode moves one word per trigger. Block mode moves the whole count on one trigger and keeps the bus until the last word. Burst mode moves the count in groups of four words and drops the bus request between groups, so the processor can use the bus in between.

When several channels wait at once, the lowest channel number is served first. A channel in the middle of a block is never cut off. When a one-shot channel finishes, it turns itself off. In both forms, a sticky done flag is set and the channel's interrupt line rises if it is enabled.

Top module: `mdma_top`

## Requirements
- R1: After reset, bus_req, mem_re, mem_we and every irq bit are 0, and every register reads as 0.
- R2: Register address cfg_addr = channel*4 + word selects the channel's registers: word 0 is control, word 1 source address, word 2 destination address, word 3 count. The address and count words read back the value last written.
- R3: Control bits are: bit 0 enable, bits 2:1 kind (0 single, 1 block, 2 burst), bit 3 repeat, bit 4 source increment, bit 5 destination increment, bit 6 interrupt enable, bits 9:8 trigger select, bit 15 done. A channel starts only on a rising edge of trig[select]; edges on the other trigger inputs are ignored.
- R4: In single kind, each trigger edge moves exactly one word, and bus_req drops after that word.
- R5: In block kind, one trigger edge moves all count words, and bus_req stays high from grant until the last write.
- R6: In burst kind, one trigger edge moves all count words in runs of at most 4 writes, and bus_req is low for at least one cycle between runs.
- R7: With repeat set, the channel reloads its count and both addresses after its last word and stays enabled, so the next trigger repeats the same copy.
- R8: Channels waiting at the same time are served lowest number first. A channel in block kind keeps the bus until its block ends, even when a lower-numbered channel becomes ready.
- R9: The source and destination addresses each step by one per word when their increment bit is 1, and stay fixed when it is 0.
- R10: After the last word, the done bit is set and irq[ch] = done AND interrupt enable. Without repeat, the enable bit also clears. Done stays set until a control write with bit 15 set.
- R11: Memory access occurs only while bus_req and bus_gnt are both high. Each word is one mem_re cycle followed directly by one mem_we cycle that writes the data just read. bus_req is held while the grant is withheld.
- R12: A channel enabled with a count of 0 never starts a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address (channel*4 + word) |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational from cfg_addr) |
| trig | input | 4 | Trigger request sources |
| bus_req | output | 1 | Bus request to the processor side |
| bus_gnt | input | 1 | Bus grant from the processor side |
| mem_re | output | 1 | Memory read strobe; data is due on mem_rdata in the next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, registered by the memory |
| irq | output | 3 | Per-channel done interrupt |

## Verification
The bench builds the block with its default parameters: three channels, four trigger inputs, 16-bit addresses, data and counts, and bursts of four. Random counts of 1 to 10 therefore cover blocks shorter than one burst, exactly one burst, and two or three bursts with partial tails. Four trigger inputs let a channel watch one line while edges arrive on the others. With three channels, two channels can wait on one shared trigger edge while a third, lower-numbered channel becomes ready in the middle of another channel's block.

// File: rtl/mdma_pkg.sv
// Package: shared encodings for the DMA controller.
// Assumes the register data width is at least 16 bits so every control field fits.
package mdma_pkg;
    // Transfer kinds held in control bits 2:1; code 3 behaves as block.
    typedef enum logic [1:0] {
        KIND_SINGLE = 2'd0,
        KIND_BLOCK  = 2'd1,
        KIND_BURST  = 2'd2
    } kind_e;

    // Transfer engine states.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_RD   = 3'd2,
        ST_WR   = 3'd3,
        ST_GAP  = 3'd4
    } eng_state_e;

    // Register word selectors inside one channel.
    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_SRC  = 2'd1;
    localparam logic [1:0] REG_DST  = 2'd2;
    localparam logic [1:0] REG_CNT  = 2'd3;

    // Control word bit positions.
    localparam int CB_EN   = 0;
    localparam int CB_KIND = 1;
    localparam int CB_REP  = 3;
    localparam int CB_SINC = 4;
    localparam int CB_DINC = 5;
    localparam int CB_IEN  = 6;
    localparam int CB_TSEL = 8;
    localparam int CB_DONE = 15;
endpackage

// File: rtl/mdma_chan.sv
// Module: one DMA channel. It holds the programmed and working addresses and count,
// watches its selected trigger, keeps the pending and done state, and advances when
// the engine reports a finished word (step).
// Assumes step is only given while ready is high.
module mdma_chan
    import mdma_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int CW       = 16,
    parameter int NUM_TRIG = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [DW-1:0]       wr_data,
    input  logic [1:0]          rd_sel,
    output logic [DW-1:0]       rd_data,
    input  logic [NUM_TRIG-1:0] trig_rise,
    input  logic                step,
    output logic                ready,
    output logic                last,
    output logic [1:0]          kind,
    output logic [AW-1:0]       cur_src,
    output logic [AW-1:0]       cur_dst,
    output logic                irq
);
    localparam int TSW = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

    logic           en, rep, sinc, dinc, ien, done, pend;
    logic [TSW-1:0] tsel;
    logic [AW-1:0]  prog_src, prog_dst;
    logic [CW-1:0]  prog_cnt, cur_cnt;
    logic [DW-1:0]  ctrl_word;
    logic           unused_wr;

    assign unused_wr = ^wr_data;
    assign ready     = en && pend && (cur_cnt != '0);
    assign last      = (cur_cnt == CW'(1));
    assign irq       = done && ien;

    // Register writes, trigger capture and per-word advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0; rep <= 1'b0; sinc <= 1'b0; dinc <= 1'b0; ien <= 1'b0;
            done <= 1'b0; pend <= 1'b0; tsel <= '0; kind <= '0;
            prog_src <= '0; prog_dst <= '0; prog_cnt <= '0;
            cur_src <= '0; cur_dst <= '0; cur_cnt <= '0;
        end else begin
            if (wr_en) begin
                case (wr_sel)
                    REG_CTRL: begin
                        en   <= wr_data[CB_EN];
                        kind <= wr_data[CB_KIND +: 2];
                        rep  <= wr_data[CB_REP];
                        sinc <= wr_data[CB_SINC];
                        dinc <= wr_data[CB_DINC];
                        ien  <= wr_data[CB_IEN];
                        tsel <= wr_data[CB_TSEL +: TSW];
                        if (wr_data[CB_DONE]) done <= 1'b0;
                        if (!wr_data[CB_EN]) pend <= 1'b0;
                        if (wr_data[CB_EN] && !en) begin
                            cur_src <= prog_src;
                            cur_dst <= prog_dst;
                            cur_cnt <= prog_cnt;
                            pend    <= 1'b0;
                        end
                    end
                    REG_SRC: prog_src <= wr_data[AW-1:0];
                    REG_DST: prog_dst <= wr_data[AW-1:0];
                    default: prog_cnt <= wr_data[CW-1:0];
                endcase
            end
            if (step) begin
                cur_src <= cur_src + AW'(sinc);
                cur_dst <= cur_dst + AW'(dinc);
                cur_cnt <= cur_cnt - 1'b1;
                if (kind == KIND_SINGLE) pend <= 1'b0;
                if (last) begin
                    done <= 1'b1;
                    pend <= 1'b0;
                    if (rep) begin
                        cur_src <= prog_src;
                        cur_dst <= prog_dst;
                        cur_cnt <= prog_cnt;
                    end else begin
                        en <= 1'b0;
                    end
                end
            end
            if (en && trig_rise[tsel]) pend <= 1'b1;
        end
    end

    // Control word image for read-back.
    always_comb begin
        ctrl_word                  = '0;
        ctrl_word[CB_EN]           = en;
        ctrl_word[CB_KIND +: 2]    = kind;
        ctrl_word[CB_REP]          = rep;
        ctrl_word[CB_SINC]         = sinc;
        ctrl_word[CB_DINC]         = dinc;
        ctrl_word[CB_IEN]          = ien;
        ctrl_word[CB_TSEL +: TSW]  = tsel;
        ctrl_word[CB_DONE]         = done;
    end

    // Read-back multiplexer.
    always_comb begin
        case (rd_sel)
            REG_CTRL: rd_data = ctrl_word;
            REG_SRC:  rd_data = DW'(prog_src);
            REG_DST:  rd_data = DW'(prog_dst);
            default:  rd_data = DW'(prog_cnt);
        endcase
    end
endmodule

// File: rtl/mdma_arb.sv
// Module: fixed-priority selector; the lowest-numbered ready channel wins.
// Purely combinational; holding a channel through a block is the engine's job.
module mdma_arb #(
    parameter int NUM_CH = 3,
    parameter int IW     = 2
) (
    input  logic [NUM_CH-1:0] req,
    output logic              valid,
    output logic [IW-1:0]     idx
);
    // Scan from highest to lowest so the lowest ready index is left in idx.
    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/mdma_engine.sv
// Module: transfer engine. It requests the bus, picks a channel at grant time,
// runs read/write word pairs and decides after each write whether to keep the bus,
// pause between bursts or release it.
// Assumes the memory returns read data one cycle after mem_re, and that the
// grant stays high while bus_req is held.
module mdma_engine
    import mdma_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int BURST_LEN = 4,
    parameter int IW        = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         arb_valid,
    input  logic [IW-1:0]                arb_idx,
    input  logic                         bus_gnt,
    input  logic [NUM_CH-1:0][AW-1:0]    src_vec,
    input  logic [NUM_CH-1:0][AW-1:0]    dst_vec,
    input  logic [NUM_CH-1:0]            last_vec,
    input  logic [NUM_CH-1:0][1:0]       kind_vec,
    input  logic [DW-1:0]                mem_rdata,
    output logic                         bus_req,
    output logic                         mem_re,
    output logic                         mem_we,
    output logic [AW-1:0]                mem_addr,
    output logic [DW-1:0]                mem_wdata,
    output logic [NUM_CH-1:0]            step_vec
);
    localparam int BCW = $clog2(BURST_LEN + 1);

    eng_state_e     state;
    logic [IW-1:0]  sel;
    logic [BCW-1:0] beat;
    logic [1:0]     cur_kind;
    logic           cur_last;

    assign cur_kind = kind_vec[sel];
    assign cur_last = last_vec[sel];

    // State sequencing, channel capture at grant and beat counting per burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel   <= '0;
            beat  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (arb_valid) state <= ST_REQ;
                ST_REQ: begin
                    if (bus_gnt) begin
                        if (arb_valid) begin
                            sel   <= arb_idx;
                            beat  <= '0;
                            state <= ST_RD;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_RD: state <= ST_WR;
                ST_WR: begin
                    beat <= beat + 1'b1;
                    if (cur_kind == KIND_SINGLE || cur_last)
                        state <= ST_IDLE;
                    else if (cur_kind == KIND_BURST && beat == BCW'(BURST_LEN - 1))
                        state <= ST_GAP;
                    else
                        state <= ST_RD;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus and memory strobes decoded from the state.
    always_comb begin
        bus_req   = (state == ST_REQ) || (state == ST_RD) || (state == ST_WR);
        mem_re    = (state == ST_RD);
        mem_we    = (state == ST_WR);
        mem_addr  = (state == ST_RD) ? src_vec[sel] : dst_vec[sel];
        mem_wdata = mem_rdata;
        step_vec  = '0;
        if (state == ST_WR) step_vec[sel] = 1'b1;
    end
endmodule

// File: rtl/mdma_top.sv
// Module: DMA controller top. It holds one channel per NUM_CH, a fixed-priority
// selector and a single transfer engine, and decodes the register port.
// Assumes trigger inputs are synchronous to clk.
module mdma_top #(
    parameter int NUM_CH    = 3,
    parameter int NUM_TRIG  = 4,
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int CW        = 16,
    parameter int BURST_LEN = 4,
    localparam int IW       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int RAW      = IW + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [RAW-1:0]      cfg_addr,
    input  logic [DW-1:0]       cfg_wdata,
    output logic [DW-1:0]       cfg_rdata,
    input  logic [NUM_TRIG-1:0] trig,
    output logic                bus_req,
    input  logic                bus_gnt,
    output logic                mem_re,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata,
    input  logic [DW-1:0]       mem_rdata,
    output logic [NUM_CH-1:0]   irq
);
    logic [NUM_TRIG-1:0]          trig_q, trig_rise;
    logic [IW-1:0]                cfg_ch, arb_idx;
    logic [NUM_CH-1:0]            ready_vec, last_vec, step_vec;
    logic [NUM_CH-1:0][1:0]       kind_vec;
    logic [NUM_CH-1:0][AW-1:0]    src_vec, dst_vec;
    logic [DW-1:0]                rd_vec [NUM_CH];
    logic                         arb_valid;

    assign cfg_ch    = cfg_addr[RAW-1:2];
    assign trig_rise = trig & ~trig_q;

    // Previous trigger levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= '0;
        else        trig_q <= trig;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        mdma_chan #(.AW(AW), .DW(DW), .CW(CW), .NUM_TRIG(NUM_TRIG)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (cfg_we && (cfg_ch == IW'(g))),
            .wr_sel    (cfg_addr[1:0]),
            .wr_data   (cfg_wdata),
            .rd_sel    (cfg_addr[1:0]),
            .rd_data   (rd_vec[g]),
            .trig_rise (trig_rise),
            .step      (step_vec[g]),
            .ready     (ready_vec[g]),
            .last      (last_vec[g]),
            .kind      (kind_vec[g]),
            .cur_src   (src_vec[g]),
            .cur_dst   (dst_vec[g]),
            .irq       (irq[g])
        );
    end

    // Read data from the addressed channel; unused channel slots read zero.
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cfg_ch == IW'(i)) cfg_rdata = rd_vec[i];
        end
    end

    mdma_arb #(.NUM_CH(NUM_CH), .IW(IW)) u_arb (
        .req   (ready_vec),
        .valid (arb_valid),
        .idx   (arb_idx)
    );

    mdma_engine #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW), .BURST_LEN(BURST_LEN), .IW(IW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .arb_valid (arb_valid),
        .arb_idx   (arb_idx),
        .bus_gnt   (bus_gnt),
        .src_vec   (src_vec),
        .dst_vec   (dst_vec),
        .last_vec  (last_vec),
        .kind_vec  (kind_vec),
        .mem_rdata (mem_rdata),
        .bus_req   (bus_req),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .step_vec  (step_vec)
    );
endmodule

// File: rtl/mdma_checker.sv
// Module: protocol checker for the DMA controller, attached to every mdma_top.
// Watches only the top-level ports.
module mdma_checker #(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              mem_re,
    input logic              mem_we,
    input logic [NUM_CH-1:0] irq
);
    assert_access_granted_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we) |-> (bus_req && bus_gnt));

    assert_read_then_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> mem_we);

    assert_write_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(mem_re));

    assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_irq
        assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq[g]) |-> $past(cfg_we));
    end
endmodule

bind mdma_top mdma_checker #(.NUM_CH(NUM_CH)) u_mdma_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .bus_req (bus_req),
    .bus_gnt (bus_gnt),
    .mem_re  (mem_re),
    .mem_we  (mem_we),
    .irq     (irq)
);

// File: tb/mdma_top_bench.sv
// Bench for mdma_top: memory and processor-grant models, directed corner cases
// and seeded random transfers checked against a bench copy model.
module mdma_top_bench;
    localparam int NCH = 3;
    localparam int NTR = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [NTR-1:0] trig = '0;
    logic        bus_req, bus_gnt = 1'b0, mem_re, mem_we;
    logic [15:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic [NCH-1:0] irq;
    bit          cpu_allow = 1'b1;

    logic [15:0] mem     [256];
    logic [15:0] exp_mem [256];
    logic [15:0] wlog    [64];
    int          wcount = 0, run = 0, max_run = 0;
    int          n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    mdma_top u_mdma_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .trig(trig),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_re(mem_re), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
    );

    // Memory, grant and write monitor models.
    always @(posedge clk) begin
        bus_gnt <= rst_n && bus_req && cpu_allow;
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wlog[wcount[5:0]] <= mem_addr;
            wcount <= wcount + 1;
        end
        if (!bus_req) run <= 0;
        else if (mem_we) begin
            run <= run + 1;
            if (run + 1 > max_run) max_run <= run + 1;
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ctrl(bit en, int kind, bit rep, bit si, bit di,
                                         bit ie, int tsel, bit clr);
        logic [15:0] w = '0;
        w[0] = en; w[2:1] = kind[1:0]; w[3] = rep; w[4] = si; w[5] = di;
        w[6] = ie; w[9:8] = tsel[1:0]; w[15] = clr;
        return w;
    endfunction

    task automatic cfg_wr(int a, logic [15:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a[3:0]; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(int a, output logic [15:0] d);
        @(negedge clk); cfg_addr = a[3:0]; #1 d = cfg_rdata;
    endtask

    task automatic pulse(int t);
        @(negedge clk); trig[t] = 1'b1;
        @(negedge clk); trig[t] = 1'b0;
    endtask

    task automatic setup(int ch, int s, int d, int n);
        cfg_wr(ch*4+1, 16'(s)); cfg_wr(ch*4+2, 16'(d)); cfg_wr(ch*4+3, 16'(n));
    endtask

    task automatic wait_irq(int ch, output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 3000 && !ok; k++) begin
            @(negedge clk);
            if (irq[ch]) ok = 1'b1;
        end
    endtask

    task automatic wait_writes(int target);
        for (int k = 0; k < 100 && wcount < target; k++) @(negedge clk);
    endtask

    task automatic model_copy(int s, int d, int n, bit si, bit di);
        for (int k = 0; k < n; k++) begin
            exp_mem[d[7:0]] = exp_mem[s[7:0]];
            s += int'(si); d += int'(di);
        end
    endtask

    task automatic compare_mem(string tag);
        int bad = 0;
        for (int k = 0; k < 256; k++) if (mem[k] !== exp_mem[k]) bad++;
        check(bad == 0, tag, bad, 0);
    endtask

    function automatic int exp_run(int kind, int n);
        if (kind == 0) return 1;
        if (kind == 1) return n;
        return (n < 4) ? n : 4;
    endfunction

    // One full transfer on a channel with random parameters, plus a repeat pass.
    task automatic run_case(int ch, int kind, bit rep, bit si, bit di, int n, int tsel);
        int s = $urandom_range(0, 40), d = 128 + $urandom_range(0, 40), w0, passes;
        bit ok;
        logic [15:0] rd;
        string tag = (kind == 0) ? "R4" : (kind == 1) ? "R5" : "R6";
        setup(ch, s, d, n);
        cfg_wr(ch*4, ctrl(1, kind, rep, si, di, 1, tsel, 0));
        passes = rep ? 2 : 1;
        for (int p = 0; p < passes; p++) begin
            w0 = wcount; max_run = 0;
            if (kind == 0) for (int k = 0; k < n; k++) begin
                pulse(tsel); wait_writes(w0 + k + 1);
            end else pulse(tsel);
            wait_irq(ch, ok);
            check(ok, "R10 irq on completion", int'(ok), 1);
            repeat (3) @(negedge clk);
            model_copy(s, d, n, si, di);
            compare_mem(p == 0 ? "R9 copy contents" : "R7 repeated copy contents");
            check(wcount - w0 == n, tag, wcount - w0, n);
            check(max_run == exp_run(kind, n), tag, max_run, exp_run(kind, n));
            cfg_rd(ch*4, rd);
            check(rd[0] == rep, rep ? "R7 stays enabled" : "R10 enable cleared", int'(rd[0]), int'(rep));
            check(rd[15] == 1'b1, "R10 done sticky", int'(rd[15]), 1);
            cfg_wr(ch*4, ctrl(rep && p == 0, kind, rep, si, di, 1, tsel, 1));
            @(negedge clk);
            check(irq[ch] == 1'b0, "R10 done cleared", int'(irq[ch]), 0);
        end
    endtask

    initial begin
        bit ok;
        logic [15:0] rd;
        int w0;
        void'($urandom(32'd2718));
        for (int k = 0; k < 256; k++) begin
            mem[k] = 16'($urandom); exp_mem[k] = mem[k];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(bus_req == 0 && mem_we == 0 && mem_re == 0, "R1 bus idle", int'(bus_req), 0);
        check(irq == '0, "R1 irq low", int'(irq), 0);
        cfg_rd(0, rd); check(rd == 16'h0, "R1 ctrl reads zero", int'(rd), 0);
        // R2: address word read-back
        cfg_wr(1*4+1, 16'h1234); cfg_rd(1*4+1, rd);
        check(rd == 16'h1234, "R2 src readback", int'(rd), 16'h1234);
        cfg_wr(2*4+3, 16'h0021); cfg_rd(2*4+3, rd);
        check(rd == 16'h0021, "R2 count readback", int'(rd), 16'h0021);
        // R3: only the selected trigger starts the channel
        setup(0, 2, 130, 4);
        cfg_wr(0, ctrl(1, 1, 0, 1, 1, 1, 2, 0));
        w0 = wcount; pulse(1); pulse(3); repeat (30) @(negedge clk);
        check(wcount == w0, "R3 other trigger ignored", wcount - w0, 0);
        pulse(2); wait_irq(0, ok);
        check(ok && wcount - w0 == 4, "R3 selected trigger starts", wcount - w0, 4);
        model_copy(2, 130, 4, 1, 1); repeat (2) @(negedge clk); compare_mem("R3 copy");
        cfg_wr(0, ctrl(0, 1, 0, 1, 1, 1, 2, 1));
        // R12: zero count never moves data
        setup(2, 5, 150, 0);
        cfg_wr(8, ctrl(1, 1, 0, 1, 1, 1, 0, 0));
        w0 = wcount; pulse(0); repeat (30) @(negedge clk);
        check(wcount == w0 && irq[2] == 0, "R12 zero count idle", wcount - w0, 0);
        cfg_wr(8, ctrl(0, 1, 0, 1, 1, 1, 0, 1));
        // R8: simultaneous triggers, lowest number first
        setup(2, 10, 170, 3); setup(0, 20, 180, 3);
        cfg_wr(8, ctrl(1, 1, 0, 1, 1, 1, 3, 0));
        cfg_wr(0, ctrl(1, 1, 0, 1, 1, 1, 3, 0));
        w0 = wcount; pulse(3); wait_irq(2, ok); repeat (3) @(negedge clk);
        check(wlog[w0[5:0]] == 16'd180, "R8 channel 0 first", int'(wlog[w0[5:0]]), 180);
        check(wcount - w0 == 6 && irq[0], "R8 both served", wcount - w0, 6);
        model_copy(20, 180, 3, 1, 1); model_copy(10, 170, 3, 1, 1); compare_mem("R8 copies");
        cfg_wr(8, ctrl(0, 1, 0, 1, 1, 1, 3, 1)); cfg_wr(0, ctrl(0, 1, 0, 1, 1, 1, 3, 1));
        // R8: block on channel 1 is not preempted by channel 0
        setup(1, 30, 140, 10); setup(0, 50, 200, 1);
        cfg_wr(4, ctrl(1, 1, 0, 1, 1, 1, 1, 0));
        cfg_wr(0, ctrl(1, 0, 0, 1, 1, 1, 0, 0));
        w0 = wcount; max_run = 0;
        pulse(1); wait_writes(w0 + 1); pulse(0);
        wait_irq(1, ok); wait_writes(w0 + 11); repeat (2) @(negedge clk);
        check(max_run == 10, "R8 block kept bus", max_run, 10);
        check(wlog[6'(w0 + 10)] == 16'd200, "R8 channel 0 after block", int'(wlog[6'(w0 + 10)]), 200);
        model_copy(30, 140, 10, 1, 1); model_copy(50, 200, 1, 1, 1); compare_mem("R8 no-preempt copies");
        cfg_wr(4, ctrl(0, 1, 0, 1, 1, 1, 1, 1)); cfg_wr(0, ctrl(0, 0, 0, 1, 1, 1, 0, 1));
        // R11: request held while grant withheld
        cpu_allow = 1'b0;
        setup(0, 60, 210, 2); cfg_wr(0, ctrl(1, 1, 0, 1, 1, 1, 0, 0));
        w0 = wcount; pulse(0); repeat (20) @(negedge clk);
        check(bus_req == 1'b1, "R11 request held", int'(bus_req), 1);
        check(wcount == w0, "R11 no access without grant", wcount - w0, 0);
        cpu_allow = 1'b1; wait_irq(0, ok); repeat (2) @(negedge clk);
        model_copy(60, 210, 2, 1, 1); compare_mem("R11 copy after grant");
        cfg_wr(0, ctrl(0, 1, 0, 1, 1, 1, 0, 1));
        // R9: fixed source and fixed destination
        run_case(1, 1, 0, 0, 1, 5, 2);
        run_case(2, 2, 0, 1, 0, 6, 3);
        // Seeded random transfers across kinds, repeat and address modes
        for (int it = 0; it < 12; it++)
            run_case($urandom_range(0, NCH-1), $urandom_range(0, 2), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     $urandom_range(1, 10), $urandom_range(0, NTR-1));
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule